// File: doc/BRIEF.md
# RMII Receive Dibit Formatter with Gap Status Signalling

This block sits between a receive nibble buffer and the reduced media-independent receive pins of an Ethernet PHY. It drives the combined carrier/data-valid line and the 2-bit receive data bus, both updated on the 50 MHz reference clock. Each buffered nibble goes out as two dibits on consecutive clocks. While carrier is present but no nibble is ready, the bus carries zeros with the valid line held high. When carrier is lost and nibbles are still buffered, the valid line alternates with each nibble so the MAC can tell loss of carrier apart from valid data.

The block reads the buffer through a first-word-fall-through interface: data is valid whenever the empty flag is low, and a one-cycle read strobe pops it. In the inter-packet gap the bus normally carries zeros. An optional mode instead places two status signals on the bus. The two signals are picked from a vector of candidates by select fields in a configuration word.

Top module: `rmii_rx_fmt`

## Requirements
- R1: While `rst_n` is low, `crs_dv_o` is 0, `rxd_o` is 2'b00 and `fifo_rd_o` is 0.
- R2: `carrier_i` passes through a two-flop synchronizer. With an empty buffer, `crs_dv_o` rises on the third rising clock edge after `carrier_i` goes high, and not on the second.
- R3: While carrier is present and the buffer is empty, `crs_dv_o` stays 1 and `rxd_o` is 2'b00. This also holds after an underrun between nibbles, and data resumes when the buffer refills.
- R4: `fifo_rd_o` pulses for one cycle, only on a nibble boundary and only when `fifo_empty_i` is 0. On the next edge `rxd_o` shows nibble bits [1:0]. On the edge after that it shows bits [3:2].
- R5: While the synchronized carrier is present, `crs_dv_o` is 1 on both dibits of every nibble.
- R6: When a nibble is sent after the synchronized carrier has dropped, `crs_dv_o` is 0 on its low dibit and 1 on its high dibit.
- R7: With carrier absent, the buffer empty and configuration bit 0 clear, `crs_dv_o` is 0 and `rxd_o` is 2'b00.
- R8: With configuration bit 0 set, each gap cycle drives `rxd_o[0]` = `status_i[cfg_i[3:1]]` and `rxd_o[1]` = `status_i[cfg_i[6:4]]`. These values are sampled at the edge that registers them, so a change in a select field shows up after one edge.
- R9: Status bits appear only after the buffer has drained. During draining, `rxd_o` carries nibble data even when configuration bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_i | input | 1 | Carrier detect, asynchronous to `clk` |
| fifo_empty_i | input | 1 | Receive buffer empty flag |
| fifo_data_i | input | 4 | Head-of-buffer nibble, valid when not empty |
| fifo_rd_o | output | 1 | Pops one nibble from the buffer |
| cfg_i | input | 7 | Bit 0 enables gap status; [3:1] selects the bit for RXD[0]; [6:4] selects the bit for RXD[1] |
| status_i | input | 8 | Candidate status signals |
| crs_dv_o | output | 1 | Carrier sense / data valid |
| rxd_o | output | 2 | Receive dibit |

## Verification
The bench builds the block with its default parameters: eight status candidates, 3-bit select fields and a two-stage synchronizer. With these values the exact three-edge assertion latency can be checked cycle by cycle. Several select indices, including index 0 and high indices, can be driven through the gap mux. A small nibble buffer in the bench lets underrun, draining after carrier loss, and draining with the status mode enabled all be set up on exact cycles.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

    // registered output and sequencing state of the formatter
    typedef struct packed {
        logic       crs;    // carrier sense / data valid output
        logic [1:0] rxd;    // dibit currently on the bus
        logic       phase;  // 1: upper dibit of held nibble is due next
        logic [1:0] hold;   // upper dibit waiting to be sent
    } fmt_state_t;

    localparam fmt_state_t FMT_RESET = '{crs: 1'b0, rxd: 2'b00, phase: 1'b0, hold: 2'b00};

endpackage

// File: rtl/rmii_rx_sync.sv
module rmii_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rmii_rx_stat_sel.sv
module rmii_rx_stat_sel #(
    parameter int STAT_N = 8,
    parameter int SEL_W  = $clog2(STAT_N)
) (
    input  logic [STAT_N-1:0] status_i,
    input  logic [SEL_W-1:0]  sel_lo_i,
    input  logic [SEL_W-1:0]  sel_hi_i,
    output logic [1:0]        pair_o
);
    // out-of-range indices (non power-of-two STAT_N) read as zero
    always_comb begin
        pair_o = 2'b00;
        for (int i = 0; i < STAT_N; i++) begin
            if (sel_lo_i == SEL_W'(i)) pair_o[0] = status_i[i];
            if (sel_hi_i == SEL_W'(i)) pair_o[1] = status_i[i];
        end
    end
endmodule

// File: rtl/rmii_rx_fmt.sv
module rmii_rx_fmt
    import rmii_rx_pkg::*;
#(
    parameter int STAT_N      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int NIB_W       = 4,
    localparam int SEL_W      = $clog2(STAT_N),
    localparam int CFG_W      = 1 + 2 * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_i,
    input  logic              fifo_empty_i,
    input  logic [NIB_W-1:0]  fifo_data_i,
    output logic              fifo_rd_o,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic [STAT_N-1:0] status_i,
    output logic              crs_dv_o,
    output logic [1:0]        rxd_o
);
    localparam int OOB_BIT = 0;
    localparam int LO_SEL  = 1;
    localparam int HI_SEL  = 1 + SEL_W;

    fmt_state_t st_d, st_q;
    logic       carrier_s;
    logic [1:0] gap_pair;
    logic       boundary;

    rmii_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (carrier_i),
        .sync_o  (carrier_s)
    );

    rmii_rx_stat_sel #(.STAT_N(STAT_N), .SEL_W(SEL_W)) u_sel (
        .status_i (status_i),
        .sel_lo_i (cfg_i[LO_SEL +: SEL_W]),
        .sel_hi_i (cfg_i[HI_SEL +: SEL_W]),
        .pair_o   (gap_pair)
    );

    assign boundary  = !st_q.phase;
    assign fifo_rd_o = rst_n && boundary && !fifo_empty_i;

    always_comb begin
        st_d = st_q;
        if (st_q.phase) begin
            // second dibit: valid always high (toggle while draining)
            st_d.rxd   = st_q.hold;
            st_d.crs   = 1'b1;
            st_d.phase = 1'b0;
        end else if (!fifo_empty_i) begin
            // first dibit: low while draining without carrier
            st_d.rxd   = fifo_data_i[1:0];
            st_d.hold  = fifo_data_i[3:2];
            st_d.crs   = carrier_s;
            st_d.phase = 1'b1;
        end else if (carrier_s) begin
            // carrier present, nothing ready: zero-stuff
            st_d.rxd = 2'b00;
            st_d.crs = 1'b1;
        end else begin
            // inter-packet gap
            st_d.crs = 1'b0;
            st_d.rxd = cfg_i[OOB_BIT] ? gap_pair : 2'b00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FMT_RESET;
        else        st_q <= st_d;
    end

    assign crs_dv_o = st_q.crs;
    assign rxd_o    = st_q.rxd;
endmodule

// File: rtl/rmii_rx_fmt_chk.sv
module rmii_rx_fmt_chk #(
    parameter int CFG_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             carrier_i,
    input logic             fifo_empty_i,
    input logic [3:0]       fifo_data_i,
    input logic             fifo_rd_o,
    input logic [CFG_W-1:0] cfg_i,
    input logic             crs_dv_o,
    input logic [1:0]       rxd_o
);
    // R4
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |=> !fifo_rd_o);

    // R4
    rd_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |-> !fifo_empty_i);

    // R4
    lo_dibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |=> (rxd_o == $past(fifo_data_i[1:0])));

    // R4
    hi_dibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |-> ##2 (rxd_o == $past(fifo_data_i[3:2], 2)));

    // R6
    drain_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fifo_rd_o) && !crs_dv_o) |=> crs_dv_o);

    // R2
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(crs_dv_o) && !$past(fifo_rd_o, 2)) |-> $past(carrier_i, 2));

    // R8
    gap_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!crs_dv_o && rxd_o != 2'b00 && !$past(fifo_rd_o)) |-> $past(cfg_i[0]));
endmodule

bind rmii_rx_fmt rmii_rx_fmt_chk #(.CFG_W(CFG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .carrier_i    (carrier_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_rd_o    (fifo_rd_o),
    .cfg_i        (cfg_i),
    .crs_dv_o     (crs_dv_o),
    .rxd_o        (rxd_o)
);

// File: tb/rmii_rx_fmt_bench.sv
module rmii_rx_fmt_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carrier = 1'b0;
    logic [6:0] cfg = '0;
    logic [7:0] status = '0;
    logic       fifo_rd, crs_dv;
    logic [1:0] rxd;

    logic [3:0] mem [0:15];
    logic [3:0] wp = '0, rp = '0;
    logic       empty;
    logic [3:0] head;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign empty = (wp == rp);
    assign head  = mem[rp];

    always @(posedge clk) if (fifo_rd) rp <= rp + 4'd1;

    rmii_rx_fmt u_rmii_rx_fmt (
        .clk          (clk),
        .rst_n        (rst_n),
        .carrier_i    (carrier),
        .fifo_empty_i (empty),
        .fifo_data_i  (head),
        .fifo_rd_o    (fifo_rd),
        .cfg_i        (cfg),
        .status_i     (status),
        .crs_dv_o     (crs_dv),
        .rxd_o        (rxd)
    );

    task automatic push(input logic [3:0] n);
        mem[wp] = n;
        wp = wp + 4'd1;
    endtask

    task automatic check(input string req, input logic exp_crs, input logic [1:0] exp_rxd);
        total++;
        if (crs_dv !== exp_crs || rxd !== exp_rxd) begin
            bad++;
            $display("FAIL %s: crs_dv=%b rxd=%b expected crs_dv=%b rxd=%b",
                     req, crs_dv, rxd, exp_crs, exp_rxd);
        end
    endtask

    // advance one edge, sample at the following falling edge
    task automatic step(input string req, input logic exp_crs, input logic [1:0] exp_rxd);
        @(negedge clk);
        check(req, exp_crs, exp_rxd);
    endtask

    task automatic t_reset();
        @(negedge clk);
        push(4'h5); // buffer not empty during reset
        @(negedge clk);
        total++;
        if (fifo_rd !== 1'b0) begin
            bad++;
            $display("FAIL R1: fifo_rd=%b expected 0", fifo_rd);
        end
        check("R1", 1'b0, 2'b00);
        rp = wp;
        @(negedge clk);
        rst_n = 1'b1;
        step("R7", 1'b0, 2'b00);
    endtask

    task automatic t_carrier_rise();
        carrier = 1'b1;
        step("R2", 1'b0, 2'b00);
        step("R2", 1'b0, 2'b00);
        step("R2", 1'b1, 2'b00);
        step("R3", 1'b1, 2'b00);
    endtask

    task automatic t_packet();
        push(4'h6); push(4'h9); push(4'hC);
        step("R4", 1'b1, 2'b10);
        step("R4", 1'b1, 2'b01);
        step("R5", 1'b1, 2'b01);
        step("R5", 1'b1, 2'b10);
        step("R4", 1'b1, 2'b00);
        step("R4", 1'b1, 2'b11);
        step("R3", 1'b1, 2'b00);
        step("R3", 1'b1, 2'b00);
        push(4'h3);
        step("R3", 1'b1, 2'b11);
        step("R3", 1'b1, 2'b00);
        step("R3", 1'b1, 2'b00);
    endtask

    task automatic t_drain_oob();
        // gap select: lo <- status[0]=0, hi <- status[5]=1
        status = 8'b1010_0110;
        cfg = {3'd5, 3'd0, 1'b1};
        carrier = 1'b0;
        push(4'hB); push(4'h4);
        step("R5", 1'b1, 2'b11);
        step("R5", 1'b1, 2'b10);
        step("R6", 1'b0, 2'b00);
        step("R9", 1'b1, 2'b01);
        step("R8", 1'b0, 2'b10);
        cfg = {3'd4, 3'd2, 1'b1};
        step("R8", 1'b0, 2'b01);
        status = 8'b0001_0000;
        step("R8", 1'b0, 2'b10);
        cfg = '0;
        step("R7", 1'b0, 2'b00);
        step("R7", 1'b0, 2'b00);
    endtask

    initial begin
        t_reset();
        t_carrier_rise();
        t_packet();
        t_drain_oob();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule